// File: doc/BRIEF.md
# Sparse Row Tile Segment-Head Generator

This block prepares the per-tile boundary information that a tiled segmented-sum pass over a compressed-sparse-row matrix needs. A tile is a fixed window of `LANE_ELEMS * LANE_COUNT` consecutive nonzeros, and tile `k` begins at nonzero index `k * TILE_N`. For each tile index it receives, the block binary-searches the row-offset array for the row that owns the tile's first nonzero. It then walks forward through the following offsets and sets a bit in a head vector at every tile position where a row begins.

Empty rows show up as repeated offsets. The block does not resolve them. If any row that begins inside the tile's range is empty, it marks the result dirty and queues the tile index in a small list, which a later correction pass drains. Offsets are read through a synchronous memory port with a one-cycle read latency. The search takes a number of steps that depends on the row count, so a result is signalled by a valid/ready handshake rather than after a fixed delay.

Top module: `tile_seg_desc`

## Requirements
- R1: After reset, `res_valid`, `dq_valid`, `dirty_full` and `dirty_ovf` are 0, and `req_ready` is 1.
- R2: `res_row` is the largest row index i in 0..`cfg_rows`-1 for which offset[i] <= `res_tile` * TILE_N. Offset[0] is 0 and offset[`cfg_rows`] is `cfg_nnz`.
- R3: `req_ready` is 0 while the dirty list is full, and a request presented then is not taken. Because of this, `dirty_ovf`, which would record a push into a full list, stays 0.
- R4: Bit p of `res_head` (bit 0 is the tile's first nonzero) is 1 exactly when some row's offset equals tile start + p and that position is valid.
- R5: Bit p of `res_mask` is 1 exactly when tile start + p < `cfg_nnz`. A partial last tile, or a tile past the end, gets a low-aligned run of ones or all zeros, and its head bits outside the mask are 0.
- R6: `res_dirty` is 1 exactly when some row j < `cfg_rows` has offset[j] == offset[j+1] and offset[j] lies in [tile start, tile end). An empty row that shares its offset with the tile start counts even when it comes before `res_row`.
- R7: Each dirty result pushes its tile index into a FIFO of `DIRTY_DEPTH` entries, and clean results push nothing. Entries leave in completion order on `dq_valid` && `dq_ready`.
- R8: While `res_valid` is 1 and `res_ready` is 0, every result field holds steady and no new request is accepted. The result is retired on `res_valid` && `res_ready`.
- R9: Offset reads go only to addresses 0..`cfg_rows`, and no read is issued while a result is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rows | input | ROW_W | Number of matrix rows (at least 1) |
| cfg_nnz | input | NNZ_W | Number of nonzeros |
| req_valid | input | 1 | Tile request present |
| req_ready | output | 1 | Block idle and dirty list not full |
| req_tile | input | TILE_W | Requested tile index |
| rp_rd_en | output | 1 | Offset memory read strobe |
| rp_rd_addr | output | ROW_W | Offset memory read address |
| rp_rd_data | input | NNZ_W | Offset data, one cycle after the strobe |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_tile | output | TILE_W | Tile index of the result |
| res_row | output | ROW_W | Row owning the tile's first nonzero |
| res_head | output | TILE_N | Row-start bit per tile position |
| res_mask | output | TILE_N | Valid-position bit per tile position |
| res_dirty | output | 1 | Tile covers an empty row |
| dq_valid | output | 1 | Dirty list not empty |
| dq_ready | input | 1 | Pop the oldest dirty index |
| dq_tile | output | TILE_W | Oldest dirty tile index |
| dirty_full | output | 1 | Dirty list full |
| dirty_ovf | output | 1 | Sticky: push attempted while full |

## Verification
The bench targets runs of equal offsets, because this is where a search that stops at the first matching entry, rather than the last, would report an empty row as the tile's owner. One case has an empty row sitting just before the owning row at the tile start. A design that only scans forward from the found row would report that tile clean, and a later pass would sum the wrong rows. Another case puts empty rows exactly at the next tile's boundary. A design that treats the range as closed at the top would flag the earlier tile dirty. The bench also covers a single-row matrix, where the search loop never runs; a partial last tile; and a tile wholly past the end, where a mask built off by one would let head bits leak into invalid lanes. Finally, it fills the dirty list and checks that a pending request stalls and that indices come back in order.

// File: rtl/tsd_pkg.sv
// Shared types for the tile segment-head generator.
package tsd_pkg;

    // Controller phases: binary search, a look-back check, the forward walk, result hold.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SRCH_RD,
        ST_SRCH_CMP,
        ST_SRCH_END,
        ST_BACK_RD,
        ST_BACK_CMP,
        ST_WALK_RD,
        ST_WALK_CMP,
        ST_RESULT
    } tsd_state_e;

endpackage

// File: rtl/tsd_ctrl.sv
// Sequencer for one tile at a time. It binary-searches the row-offset array
// for the owning row, optionally looks one row back for an empty row at the
// tile start, then walks forward marking row starts until an offset reaches
// the tile end. Assumes offset[0] == 0, offset[rows] == nnz, rows >= 1, and
// that tile*TILE_N fits in NNZ_W+1 bits. Memory reads return one cycle later.
module tsd_ctrl
    import tsd_pkg::*;
#(
    parameter int TILE_N = 16,
    parameter int ROW_W  = 8,
    parameter int NNZ_W  = 12,
    parameter int TILE_W = 8,
    localparam int POS_W = $clog2(TILE_N),
    localparam int CNT_W = $clog2(TILE_N + 1),
    localparam int EXT_W = NNZ_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [NNZ_W-1:0]  cfg_nnz,
    input  logic              req_valid,
    input  logic [TILE_W-1:0] req_tile,
    output logic              req_ready,
    input  logic              fifo_full,
    output logic              rd_en,
    output logic [ROW_W-1:0]  rd_addr,
    input  logic [NNZ_W-1:0]  rd_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [TILE_W-1:0] res_tile,
    output logic [ROW_W-1:0]  res_row,
    output logic              res_dirty,
    output logic              clr,
    output logic              mark_en,
    output logic [POS_W-1:0]  mark_pos,
    output logic              push,
    output logic [CNT_W-1:0]  valid_cnt
);

    tsd_state_e        state_q, state_d;
    logic [TILE_W-1:0] tile_q;
    logic [EXT_W-1:0]  start_q, end_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ROW_W-1:0]  lo_q, hi_q;
    logic [EXT_W-1:0]  lo_val_q;
    logic [ROW_W:0]    r_q;
    logic [EXT_W-1:0]  prev_q;
    logic              dirty_q;

    logic              accept;
    logic [EXT_W-1:0]  tile_start_w, nnz_ext, room_w, end_w, data_ext;
    logic              in_range, room_big;
    logic [CNT_W-1:0]  cnt_w;
    logic [ROW_W-1:0]  mid, srch_lo, srch_hi;
    logic              probe_le, walk_stop, at_head, r_past;

    // Request acceptance and tile range arithmetic.
    assign accept       = (state_q == ST_IDLE) && req_valid && !fifo_full;
    assign req_ready    = (state_q == ST_IDLE) && !fifo_full;
    assign tile_start_w = EXT_W'(req_tile) * EXT_W'(TILE_N);
    assign nnz_ext      = EXT_W'(cfg_nnz);
    assign in_range     = nnz_ext > tile_start_w;
    assign room_w       = nnz_ext - tile_start_w;
    assign room_big     = room_w > EXT_W'(TILE_N);
    assign end_w        = (in_range && room_big) ? tile_start_w + EXT_W'(TILE_N) : nnz_ext;
    assign cnt_w        = !in_range ? '0 : (room_big ? CNT_W'(TILE_N) : CNT_W'(room_w));

    // Search and walk comparisons on the returned offset.
    assign data_ext  = EXT_W'(rd_data);
    assign mid       = lo_q + ((hi_q - lo_q) >> 1);
    assign probe_le  = data_ext <= start_q;
    assign srch_lo   = probe_le ? mid : lo_q;
    assign srch_hi   = probe_le ? hi_q : mid;
    assign walk_stop = data_ext >= end_q;
    assign at_head   = lo_val_q == start_q;
    assign r_past    = r_q > {1'b0, cfg_rows};

    // Next-state and memory-port decode.
    always_comb begin
        state_d  = state_q;
        rd_en    = 1'b0;
        rd_addr  = '0;
        mark_en  = 1'b0;
        mark_pos = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (cfg_rows > ROW_W'(1)) ? ST_SRCH_RD : ST_SRCH_END;
            end
            ST_SRCH_RD: begin
                rd_en   = 1'b1;
                rd_addr = mid;
                state_d = ST_SRCH_CMP;
            end
            ST_SRCH_CMP: begin
                state_d = ((srch_hi - srch_lo) > ROW_W'(1)) ? ST_SRCH_RD : ST_SRCH_END;
            end
            ST_SRCH_END: begin
                mark_en = at_head;
                state_d = (at_head && (lo_q != '0) && (start_q < end_q)) ? ST_BACK_RD : ST_WALK_RD;
            end
            ST_BACK_RD: begin
                rd_en   = 1'b1;
                rd_addr = lo_q - ROW_W'(1);
                state_d = ST_BACK_CMP;
            end
            ST_BACK_CMP: begin
                state_d = ST_WALK_RD;
            end
            ST_WALK_RD: begin
                if (r_past) begin
                    state_d = ST_RESULT;
                end else begin
                    rd_en   = 1'b1;
                    rd_addr = r_q[ROW_W-1:0];
                    state_d = ST_WALK_CMP;
                end
            end
            ST_WALK_CMP: begin
                if (walk_stop) begin
                    state_d = ST_RESULT;
                end else begin
                    mark_en  = 1'b1;
                    mark_pos = POS_W'(data_ext - start_q);
                    state_d  = ST_WALK_RD;
                end
            end
            ST_RESULT: begin
                if (res_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-tile datapath registers: range, search bounds, walk cursor, dirty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tile_q   <= '0;
            start_q  <= '0;
            end_q    <= '0;
            cnt_q    <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
            lo_val_q <= '0;
            r_q      <= '0;
            prev_q   <= '0;
            dirty_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        tile_q   <= req_tile;
                        start_q  <= tile_start_w;
                        end_q    <= end_w;
                        cnt_q    <= cnt_w;
                        lo_q     <= '0;
                        hi_q     <= cfg_rows;
                        lo_val_q <= '0;
                        dirty_q  <= 1'b0;
                    end
                end
                ST_SRCH_CMP: begin
                    lo_q <= srch_lo;
                    hi_q <= srch_hi;
                    if (probe_le) lo_val_q <= data_ext;
                end
                ST_SRCH_END: begin
                    r_q    <= {1'b0, lo_q} + (ROW_W + 1)'(1);
                    prev_q <= lo_val_q;
                end
                ST_BACK_CMP: begin
                    if (data_ext == start_q) dirty_q <= 1'b1;
                end
                ST_WALK_CMP: begin
                    if (!walk_stop) begin
                        if (data_ext == prev_q) dirty_q <= 1'b1;
                        prev_q <= data_ext;
                        r_q    <= r_q + (ROW_W + 1)'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Result view and handshakes towards the neighbours.
    assign clr       = accept;
    assign push      = (state_d == ST_RESULT) && (state_q != ST_RESULT) && dirty_q;
    assign res_valid = state_q == ST_RESULT;
    assign res_tile  = tile_q;
    assign res_row   = lo_q;
    assign res_dirty = dirty_q;
    assign valid_cnt = cnt_q;

endmodule

// File: rtl/tsd_head_acc.sv
// Collects row-start marks into the head vector and derives the valid mask
// from the count of in-range positions. Head bits outside the mask are hidden.
module tsd_head_acc #(
    parameter int TILE_N = 16,
    localparam int POS_W = $clog2(TILE_N),
    localparam int CNT_W = $clog2(TILE_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mark_en,
    input  logic [POS_W-1:0]  mark_pos,
    input  logic [CNT_W-1:0]  valid_cnt,
    output logic [TILE_N-1:0] head,
    output logic [TILE_N-1:0] mask
);

    logic [TILE_N-1:0] head_q;

    // Head accumulator: cleared per tile, one bit set per mark.
    always_ff @(posedge clk) begin
        if (!rst_n)       head_q <= '0;
        else if (clr)     head_q <= '0;
        else if (mark_en) head_q[mark_pos] <= 1'b1;
    end

    // One comparator per lane builds the low-aligned valid mask.
    for (genvar p = 0; p < TILE_N; p++) begin : g_lane
        assign mask[p] = valid_cnt > CNT_W'(p);
    end

    assign head = head_q & mask;

endmodule

// File: rtl/tsd_dirty_fifo.sv
// Small circular FIFO holding tile indices that need repair. A push into a
// full FIFO is dropped and sets a sticky overflow flag.
module tsd_dirty_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         full,
    output logic         ovf
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full      = cnt == CNT_W'(DEPTH);
    assign out_valid = cnt != '0;
    assign out_data  = mem[rd_ptr];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && pop_ready;

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointers, occupancy and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            if (do_push && !do_pop)      cnt <= cnt + CNT_W'(1);
            else if (do_pop && !do_push) cnt <= cnt - CNT_W'(1);
            if (push && full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/tile_seg_desc.sv
// Top of the tile segment-head generator: sequencer, head accumulator and
// dirty-tile FIFO. One tile is processed at a time; a new request waits until
// the previous result is taken and the dirty FIFO has room.
module tile_seg_desc #(
    parameter int LANE_ELEMS  = 4,
    parameter int LANE_COUNT  = 4,
    parameter int ROW_W       = 8,
    parameter int NNZ_W       = 12,
    parameter int TILE_W      = 8,
    parameter int DIRTY_DEPTH = 4,
    localparam int TILE_N = LANE_ELEMS * LANE_COUNT,
    localparam int POS_W  = $clog2(TILE_N),
    localparam int CNT_W  = $clog2(TILE_N + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [NNZ_W-1:0]  cfg_nnz,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TILE_W-1:0] req_tile,
    output logic              rp_rd_en,
    output logic [ROW_W-1:0]  rp_rd_addr,
    input  logic [NNZ_W-1:0]  rp_rd_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [TILE_W-1:0] res_tile,
    output logic [ROW_W-1:0]  res_row,
    output logic [TILE_N-1:0] res_head,
    output logic [TILE_N-1:0] res_mask,
    output logic              res_dirty,
    output logic              dq_valid,
    input  logic              dq_ready,
    output logic [TILE_W-1:0] dq_tile,
    output logic              dirty_full,
    output logic              dirty_ovf
);

    logic             clr, mark_en, push;
    logic [POS_W-1:0] mark_pos;
    logic [CNT_W-1:0] valid_cnt;

    tsd_ctrl #(
        .TILE_N (TILE_N),
        .ROW_W  (ROW_W),
        .NNZ_W  (NNZ_W),
        .TILE_W (TILE_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_rows  (cfg_rows),
        .cfg_nnz   (cfg_nnz),
        .req_valid (req_valid),
        .req_tile  (req_tile),
        .req_ready (req_ready),
        .fifo_full (dirty_full),
        .rd_en     (rp_rd_en),
        .rd_addr   (rp_rd_addr),
        .rd_data   (rp_rd_data),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_tile  (res_tile),
        .res_row   (res_row),
        .res_dirty (res_dirty),
        .clr       (clr),
        .mark_en   (mark_en),
        .mark_pos  (mark_pos),
        .push      (push),
        .valid_cnt (valid_cnt)
    );

    tsd_head_acc #(
        .TILE_N (TILE_N)
    ) u_head (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .mark_en   (mark_en),
        .mark_pos  (mark_pos),
        .valid_cnt (valid_cnt),
        .head      (res_head),
        .mask      (res_mask)
    );

    tsd_dirty_fifo #(
        .DEPTH (DIRTY_DEPTH),
        .W     (TILE_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (res_tile),
        .pop_ready (dq_ready),
        .out_valid (dq_valid),
        .out_data  (dq_tile),
        .full      (dirty_full),
        .ovf       (dirty_ovf)
    );

endmodule

// File: rtl/tsd_checker.sv
// Protocol and consistency properties for tile_seg_desc, attached by bind.
module tsd_checker #(
    parameter int TILE_N = 16,
    parameter int ROW_W  = 8,
    parameter int TILE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              res_valid,
    input logic              res_ready,
    input logic [TILE_W-1:0] res_tile,
    input logic [ROW_W-1:0]  res_row,
    input logic [TILE_N-1:0] res_head,
    input logic [TILE_N-1:0] res_mask,
    input logic              res_dirty,
    input logic              rp_rd_en,
    input logic [ROW_W-1:0]  rp_rd_addr,
    input logic [ROW_W-1:0]  cfg_rows,
    input logic              dq_valid,
    input logic              dirty_full,
    input logic              dirty_ovf
);

    // R3: a full dirty list blocks requests, so no push is ever lost.
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_full |-> !req_ready);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dirty_ovf);

    // R5: mask is a low-aligned run of ones and head stays inside it.
    p_head_in_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_head & ~res_mask) == '0));
    p_mask_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_mask & (res_mask + TILE_N'(1))) == '0));

    // R7: a full list always offers an entry.
    p_full_offers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_full |-> dq_valid);

    // R8: a stalled result holds every field and blocks new work.
    p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_head) && $stable(res_mask)
            && $stable(res_row) && $stable(res_tile) && $stable(res_dirty)));
    p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);

    // R9: reads stay inside the offset array and stop while a result waits.
    p_rd_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rp_rd_en |-> (rp_rd_addr <= cfg_rows));
    p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !rp_rd_en);

endmodule

bind tile_seg_desc tsd_checker #(
    .TILE_N (TILE_N),
    .ROW_W  (ROW_W),
    .TILE_W (TILE_W)
) u_tsd_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .res_valid  (res_valid),
    .res_ready  (res_ready),
    .res_tile   (res_tile),
    .res_row    (res_row),
    .res_head   (res_head),
    .res_mask   (res_mask),
    .res_dirty  (res_dirty),
    .rp_rd_en   (rp_rd_en),
    .rp_rd_addr (rp_rd_addr),
    .cfg_rows   (cfg_rows),
    .dq_valid   (dq_valid),
    .dirty_full (dirty_full),
    .dirty_ovf  (dirty_ovf)
);

// File: tb/test_tile_seg_desc.sv
`timescale 1ns/1ps
module test_tile_seg_desc;

    localparam int TILE_N = 16;

    // Vector fields: tile[48:41] row[40:33] head[32:17] mask[16:1] dirty[0].
    // Matrix A offsets: 0,3,3,10,16,16,16,20,33,40,45 (10 rows, 45 nonzeros).
    localparam logic [48:0] VEC [4] = '{
        {8'd0, 8'd0, 16'h0409, 16'hFFFF, 1'b1},
        {8'd1, 8'd6, 16'h0011, 16'hFFFF, 1'b1},
        {8'd2, 8'd7, 16'h0102, 16'h1FFF, 1'b0},
        {8'd3, 8'd9, 16'h0000, 16'h0000, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        cfg_rows = 8'd10;
    logic [11:0]       cfg_nnz = 12'd45;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [7:0]        req_tile = '0;
    logic              rp_rd_en;
    logic [7:0]        rp_rd_addr;
    logic [11:0]       rp_rd_data;
    logic              res_valid;
    logic              res_ready = 1'b0;
    logic [7:0]        res_tile;
    logic [7:0]        res_row;
    logic [TILE_N-1:0] res_head;
    logic [TILE_N-1:0] res_mask;
    logic              res_dirty;
    logic              dq_valid;
    logic              dq_ready = 1'b0;
    logic [7:0]        dq_tile;
    logic              dirty_full;
    logic              dirty_ovf;

    logic [11:0] rp_mem [256];
    int n_checks = 0;
    int n_fail = 0;
    int bad_reads = 0;

    always #2.5 clk = ~clk;

    tile_seg_desc i_tile_seg_desc (
        .clk(clk), .rst_n(rst_n), .cfg_rows(cfg_rows), .cfg_nnz(cfg_nnz),
        .req_valid(req_valid), .req_ready(req_ready), .req_tile(req_tile),
        .rp_rd_en(rp_rd_en), .rp_rd_addr(rp_rd_addr), .rp_rd_data(rp_rd_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_tile(res_tile),
        .res_row(res_row), .res_head(res_head), .res_mask(res_mask),
        .res_dirty(res_dirty), .dq_valid(dq_valid), .dq_ready(dq_ready),
        .dq_tile(dq_tile), .dirty_full(dirty_full), .dirty_ovf(dirty_ovf)
    );

    // Offset memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (rp_rd_en) rp_rd_data <= rp_mem[rp_rd_addr];
    end

    // R9 monitor: counts reads outside 0..rows.
    always @(posedge clk) begin
        if (rst_n && rp_rd_en && (rp_rd_addr > cfg_rows)) bad_reads++;
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic load_a();
        for (int i = 0; i < 256; i++) rp_mem[i] = '0;
        rp_mem[0] = 0;  rp_mem[1] = 3;  rp_mem[2] = 3;  rp_mem[3] = 10;
        rp_mem[4] = 16; rp_mem[5] = 16; rp_mem[6] = 16; rp_mem[7] = 20;
        rp_mem[8] = 33; rp_mem[9] = 40; rp_mem[10] = 45;
        cfg_rows = 8'd10;
        cfg_nnz  = 12'd45;
    endtask

    task automatic send_req(input logic [7:0] t);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_tile  = t;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take_res(input logic [7:0] t, input logic [7:0] row,
                            input logic [15:0] head, input logic [15:0] mask,
                            input logic dirty, input bit hold);
        int w = 0;
        while (!res_valid && w < 500) begin
            @(negedge clk);
            w++;
        end
        check(32'(res_valid), 32'd1, "R8 result valid");
        check(32'(res_tile), 32'(t), "R8 result tile");
        check(32'(res_row), 32'(row), "R2 start row");
        check(32'(res_head), 32'(head), "R4 head vector");
        check(32'(res_mask), 32'(mask), "R5 valid mask");
        check(32'(res_dirty), 32'(dirty), "R6 dirty bit");
        if (hold) begin
            repeat (3) @(negedge clk);
            check(32'(res_valid), 32'd1, "R8 valid held");
            check(32'(res_head), 32'(head), "R8 head held");
            check(32'(req_ready), 32'd0, "R8 busy while waiting");
        end
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    task automatic pop_expect(input logic [7:0] t);
        check(32'(dq_valid), 32'd1, "R7 dirty entry present");
        check(32'(dq_tile), 32'(t), "R7 dirty entry order");
        dq_ready = 1'b1;
        @(negedge clk);
        dq_ready = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1-wide run actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        load_a();
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(32'(res_valid), 32'd0, "R1 res_valid in reset");
        check(32'(dq_valid), 32'd0, "R1 dq_valid in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(32'(req_ready), 32'd1, "R1 req_ready after reset");
        check(32'(dirty_full), 32'd0, "R1 dirty_full after reset");
        check(32'(dirty_ovf), 32'd0, "R1 dirty_ovf after reset");

        // Table walk over matrix A.
        for (int i = 0; i < 4; i++) begin
            send_req(VEC[i][48:41]);
            take_res(VEC[i][48:41], VEC[i][40:33], VEC[i][32:17], VEC[i][16:1], VEC[i][0], i == 1);
        end
        // R7: only the two dirty tiles were queued, in order.
        pop_expect(8'd0);
        pop_expect(8'd1);
        check(32'(dq_valid), 32'd0, "R7 clean tiles not queued");

        // Matrix B: single row of 20 nonzeros (no search steps, partial tile).
        for (int i = 0; i < 256; i++) rp_mem[i] = '0;
        rp_mem[1] = 20;
        cfg_rows = 8'd1;
        cfg_nnz  = 12'd20;
        send_req(8'd0);
        take_res(8'd0, 8'd0, 16'h0001, 16'hFFFF, 1'b0, 1'b0);
        send_req(8'd1);
        take_res(8'd1, 8'd0, 16'h0000, 16'h000F, 1'b0, 1'b0);

        // Matrix C: offsets 0,16,16,16,32; empty rows sit at the tile-1 start.
        rp_mem[0] = 0; rp_mem[1] = 16; rp_mem[2] = 16; rp_mem[3] = 16; rp_mem[4] = 32;
        cfg_rows = 8'd4;
        cfg_nnz  = 12'd32;
        send_req(8'd0);
        take_res(8'd0, 8'd0, 16'h0001, 16'hFFFF, 1'b0, 1'b0);  // R6 boundary is exclusive
        send_req(8'd1);
        take_res(8'd1, 8'd3, 16'h0001, 16'hFFFF, 1'b1, 1'b0);  // R6 look-back empty row
        pop_expect(8'd1);

        // R3: fill the dirty list, then a new request must stall.
        load_a();
        for (int i = 0; i < 4; i++) begin
            send_req(8'(i % 2));
            take_res(8'(i % 2), VEC[i % 2][40:33], VEC[i % 2][32:17], VEC[i % 2][16:1], 1'b1, 1'b0);
        end
        check(32'(dirty_full), 32'd1, "R3 list full");
        check(32'(req_ready), 32'd0, "R3 ready low when full");
        req_valid = 1'b1;
        req_tile  = 8'd2;
        repeat (4) @(negedge clk);
        check(32'(res_valid), 32'd0, "R3 request not taken while full");
        check(32'(req_ready), 32'd0, "R3 still stalled");
        req_valid = 1'b0;
        pop_expect(8'd0);
        pop_expect(8'd1);
        pop_expect(8'd0);
        pop_expect(8'd1);
        check(32'(dq_valid), 32'd0, "R7 list drained");
        check(32'(dirty_ovf), 32'd0, "R3 overflow never set");
        check(32'(bad_reads), 32'd0, "R9 reads inside offset array");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule